// File: doc/BRIEF.md
# Dual Compare Free-Running Timer

This block is a 16-bit up-counter that runs freely while enabled and advances once per single-cycle `tick`. Two compare channels watch the counter. The first channel can also send the counter back to zero. Each match, and each roll-over past the top count, sets a sticky status flag. Each flag can be enabled to raise an interrupt request. Both the request and its code are registered outputs, so the CPU side only needs to sample them.

Software reaches the timer over a byte-wide register bus inside an eight-byte window. The counter and the two compare values are 16 bits wide, so software moves them as two bytes. A high byte that is written waits in a holding register and is committed together with the low byte that follows. A read of the counter's high byte captures a snapshot of the low byte, so the two halves always belong together. The two compare registers share one address pair, and a bank bit chooses which one it reaches.

Top module: `dual_cmp_timer`

## Requirements
- R1: After reset, the interrupt-enable, status, count-control and bank bytes read 0x00, the counter reads 0x0000, both compare registers read 0xFFFF, and irq_req is low.
- R2: The window starts at BASE_ADDR (default 0xFF90), using byte offsets: 0 enables (bit3 compare A, bit2 compare B, bit1 wrap; other bits read 0), 1 status (bit3 flag A, bit2 flag B, bit1 wrap flag, bit0 clear-on-A), 2/3 counter high/low, 4/5 compare high/low, 6 count control (bit0 count enable), 7 bank (bit0). Read data appears on bus_rdata on the clock edge that samples the read.
- R3: When count enable is 1, every tick adds one to the counter. With count enable at 0 the counter holds its value.
- R4: A write to a high byte (offset 2 or 4) only loads a holding register. The 16-bit register changes on the following low-byte write and takes {held, written}. A read of offset 3 returns the low byte captured at the most recent read of offset 2.
- R5: Bank 0 sends compare accesses at offsets 4/5 to compare A, and bank 1 sends them to compare B, for both reads and writes.
- R6: On a counted tick where the counter before the increment equals compare A, flag A sets. The counter then becomes 0x0000 if clear-on-A is 1, and otherwise it increments.
- R7: On a counted tick where the counter equals compare B, flag B sets. Compare B never clears the counter.
- R8: A counted tick at 0xFFFF that is not cleared by compare A wraps the counter to 0x0000 and sets the wrap flag.
- R9: A status flag clears only when 0 is written to it after a status read that returned it as 1. Writing 1 has no effect. Writing 0 with no such prior read has no effect.
- R10: When a low-byte counter write coincides with a tick, the written value is loaded. That cycle has no increment, sets no compare flag and sets no wrap flag.
- R11: irq_req goes high one clock after any flag whose enable bit is 1 is set, and stays high while such a flag remains.
- R12: irq_code reports the highest pending enabled source: 18 for wrap, 17 for compare B, 16 for compare A.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle count strobe |
| bus_sel | input | 1 | Bus access valid this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq_req | output | 1 | Registered interrupt request level |
| irq_code | output | CODE_W | Code of the highest pending enabled source |

## Verification
On every cycle, the assertions check the counter's step rules: hold, increment, clear on compare A, and the priority of a bus load. They also check that a wrap raises its flag, that the request level follows the enabled flags one clock later, and that a pending wrap always wins the code. Several behaviours can only be shown by the bench's scenarios, because each depends on a sequence of bus accesses. These are the read-then-write-zero rule for clearing flags, the staging of high bytes, the low-byte snapshot, the bank selection of the shared compare address, and the collision of a tick with a counter write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 16;
  localparam int N_CMP  = 2;
  localparam int N_EVT  = 3;
  localparam int OFS_W  = 3;

  localparam logic [OFS_W-1:0] OFS_IEN  = 3'd0;
  localparam logic [OFS_W-1:0] OFS_STAT = 3'd1;
  localparam logic [OFS_W-1:0] OFS_CNTH = 3'd2;
  localparam logic [OFS_W-1:0] OFS_CNTL = 3'd3;
  localparam logic [OFS_W-1:0] OFS_CMPH = 3'd4;
  localparam logic [OFS_W-1:0] OFS_CMPL = 3'd5;
  localparam logic [OFS_W-1:0] OFS_CTRL = 3'd6;
  localparam logic [OFS_W-1:0] OFS_BANK = 3'd7;

  localparam int EV_A   = 0;
  localparam int EV_B   = 1;
  localparam int EV_WRP = 2;

  localparam int BIT_CLRA = 0;

  typedef logic [CNT_W-1:0]  cnt_t;
  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [N_EVT-1:0]  evt_t;

  function automatic int evt_bit(input int ev);
    return 3 - ev;
  endfunction
endpackage

// File: rtl/tmr_counter.sv
module tmr_counter
  import tmr_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        tick_en,
  input  logic                        ld,
  input  cnt_t                        ld_val,
  input  logic                        clr_on_a,
  input  logic [N_CMP-1:0][CNT_W-1:0] cmp_vals,
  output cnt_t                        cnt_q,
  output logic [N_CMP-1:0]            match,
  output logic                        wrap
);
  localparam cnt_t TOP = '1;

  logic step;
  logic clr;
  assign step = tick_en && !ld;

  for (genvar g = 0; g < N_CMP; g++) begin : g_cmp
    assign match[g] = step && (cnt_q == cnt_t'(cmp_vals[g]));
  end

  assign clr  = match[EV_A] && clr_on_a;
  assign wrap = step && !clr && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (ld) begin
      cnt_q <= ld_val;
    end else if (clr) begin
      cnt_q <= '0;
    end else if (step) begin
      cnt_q <= cnt_q + cnt_t'(1);
    end
  end
endmodule

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF90
)(
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        bus_sel,
  input  logic                        bus_we,
  input  logic [ADDR_W-1:0]           bus_addr,
  input  byte_t                       bus_wdata,
  output byte_t                       bus_rdata,
  input  cnt_t                        cnt_q,
  input  evt_t                        evt,
  output evt_t                        flags,
  output evt_t                        ien,
  output logic                        clr_on_a,
  output logic                        cnt_en,
  output logic                        cnt_ld,
  output cnt_t                        cnt_ld_val,
  output logic [N_CMP-1:0][CNT_W-1:0] cmp_vals
);
  localparam int HI_W = ADDR_W - OFS_W;
  localparam logic [HI_W-1:0] BASE_HI = BASE_ADDR[ADDR_W-1:OFS_W];

  logic             hit, wr, rd;
  logic [OFS_W-1:0] ofs;
  logic             bank;
  byte_t            hold_hi;
  byte_t            snap_lo;
  evt_t             armed;
  logic             wr_stat, rd_stat;
  byte_t            stat_byte, ien_byte;
  cnt_t             cmp_sel;

  assign hit     = bus_sel && (bus_addr[ADDR_W-1:OFS_W] == BASE_HI);
  assign ofs     = bus_addr[OFS_W-1:0];
  assign wr      = hit && bus_we;
  assign rd      = hit && !bus_we;
  assign wr_stat = wr && (ofs == OFS_STAT);
  assign rd_stat = rd && (ofs == OFS_STAT);

  assign cnt_ld     = wr && (ofs == OFS_CNTL);
  assign cnt_ld_val = {hold_hi, bus_wdata};
  assign cmp_sel    = cmp_vals[bank];

  always_comb begin
    stat_byte = '0;
    ien_byte  = '0;
    for (int i = 0; i < N_EVT; i++) begin
      stat_byte[evt_bit(i)] = flags[i];
      ien_byte[evt_bit(i)]  = ien[i];
    end
    stat_byte[BIT_CLRA] = clr_on_a;
  end

  // Flag set/arm/clear, one slice per event source
  for (genvar g = 0; g < N_EVT; g++) begin : g_flag
    logic clr_g;
    assign clr_g = wr_stat && !bus_wdata[evt_bit(g)] && armed[g];
    always_ff @(posedge clk) begin
      if (rst) begin
        flags[g] <= 1'b0;
        armed[g] <= 1'b0;
      end else begin
        if (evt[g])     flags[g] <= 1'b1;
        else if (clr_g) flags[g] <= 1'b0;
        if (clr_g)        armed[g] <= 1'b0;
        else if (rd_stat) armed[g] <= flags[g];
      end
    end
  end

  // Control registers
  always_ff @(posedge clk) begin
    if (rst) begin
      ien      <= '0;
      clr_on_a <= 1'b0;
      cnt_en   <= 1'b0;
      bank     <= 1'b0;
      hold_hi  <= '0;
    end else if (wr) begin
      case (ofs)
        OFS_IEN: begin
          for (int i = 0; i < N_EVT; i++) ien[i] <= bus_wdata[evt_bit(i)];
        end
        OFS_STAT: clr_on_a <= bus_wdata[BIT_CLRA];
        OFS_CNTH: hold_hi  <= bus_wdata;
        OFS_CMPH: hold_hi  <= bus_wdata;
        OFS_CTRL: cnt_en   <= bus_wdata[0];
        OFS_BANK: bank     <= bus_wdata[0];
        default: ;
      endcase
    end
  end

  // Compare registers, one per channel
  for (genvar g = 0; g < N_CMP; g++) begin : g_cmpreg
    always_ff @(posedge clk) begin
      if (rst) begin
        cmp_vals[g] <= '1;
      end else if (wr && (ofs == OFS_CMPL) && (int'(bank) == g)) begin
        cmp_vals[g] <= {hold_hi, bus_wdata};
      end
    end
  end

  // Registered read path with low-byte snapshot
  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      snap_lo   <= '0;
    end else if (rd) begin
      case (ofs)
        OFS_IEN:  bus_rdata <= ien_byte;
        OFS_STAT: bus_rdata <= stat_byte;
        OFS_CNTH: begin
          bus_rdata <= cnt_q[CNT_W-1:BYTE_W];
          snap_lo   <= cnt_q[BYTE_W-1:0];
        end
        OFS_CNTL: bus_rdata <= snap_lo;
        OFS_CMPH: bus_rdata <= cmp_sel[CNT_W-1:BYTE_W];
        OFS_CMPL: bus_rdata <= cmp_sel[BYTE_W-1:0];
        OFS_CTRL: bus_rdata <= {7'd0, cnt_en};
        default:  bus_rdata <= {7'd0, bank};
      endcase
    end
  end
endmodule

// File: rtl/tmr_irq.sv
module tmr_irq
  import tmr_pkg::*;
#(
  parameter int                CODE_W   = 5,
  parameter logic [CODE_W-1:0] CODE_A   = 5'd16,
  parameter logic [CODE_W-1:0] CODE_B   = 5'd17,
  parameter logic [CODE_W-1:0] CODE_WRP = 5'd18
)(
  input  logic              clk,
  input  logic              rst,
  input  evt_t              flags,
  input  evt_t              ien,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code
);
  evt_t              pend;
  logic [CODE_W-1:0] code_d;

  assign pend = flags & ien;

  always_comb begin
    code_d = '0;
    if (pend[EV_A])   code_d = CODE_A;
    if (pend[EV_B])   code_d = CODE_B;
    if (pend[EV_WRP]) code_d = CODE_WRP;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_req  <= 1'b0;
      irq_code <= '0;
    end else begin
      irq_req  <= |pend;
      irq_code <= code_d;
    end
  end
endmodule

// File: rtl/dual_cmp_timer.sv
module dual_cmp_timer
  import tmr_pkg::*;
#(
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hFF90,
  parameter int                CODE_W    = 5
)(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  output logic              irq_req,
  output logic [CODE_W-1:0] irq_code
);
  cnt_t                        cnt_q;
  evt_t                        evt, flags, ien;
  logic                        clr_on_a, cnt_en, cnt_ld, tick_en, wrap;
  cnt_t                        cnt_ld_val;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_vals;
  logic [N_CMP-1:0]            match;
  cnt_t                        cmp_a_w;

  assign tick_en = tick && cnt_en;
  assign cmp_a_w = cmp_vals[EV_A];
  assign evt     = {wrap, match[EV_B], match[EV_A]};

  tmr_regs #(.ADDR_W(ADDR_W), .BASE_ADDR(BASE_ADDR)) u_regs (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cnt_q(cnt_q), .evt(evt), .flags(flags), .ien(ien),
    .clr_on_a(clr_on_a), .cnt_en(cnt_en), .cnt_ld(cnt_ld),
    .cnt_ld_val(cnt_ld_val), .cmp_vals(cmp_vals)
  );

  tmr_counter u_cnt (
    .clk(clk), .rst(rst), .tick_en(tick_en), .ld(cnt_ld),
    .ld_val(cnt_ld_val), .clr_on_a(clr_on_a), .cmp_vals(cmp_vals),
    .cnt_q(cnt_q), .match(match), .wrap(wrap)
  );

  tmr_irq #(.CODE_W(CODE_W)) u_irq (
    .clk(clk), .rst(rst), .flags(flags), .ien(ien),
    .irq_req(irq_req), .irq_code(irq_code)
  );
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int CODE_W = 5
)(
  input logic              clk,
  input logic              rst,
  input logic              tick_en,
  input logic              cnt_ld,
  input cnt_t              cnt_ld_val,
  input cnt_t              cnt_q,
  input cnt_t              cmp_a,
  input logic              clr_on_a,
  input evt_t              flags,
  input evt_t              ien,
  input logic              irq_req,
  input logic [CODE_W-1:0] irq_code
);
  logic clr_hit;
  assign clr_hit = tick_en && !cnt_ld && (cnt_q == cmp_a) && clr_on_a;

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (!tick_en && !cnt_ld) |=> $stable(cnt_q));

  p_inc_r3: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_ld && !clr_hit) |=> (cnt_q == cnt_t'($past(cnt_q) + cnt_t'(1))));

  p_clear_a_r6: assert property (@(posedge clk) disable iff (rst)
    clr_hit |=> (cnt_q == '0) && flags[EV_A]);

  p_wrap_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (tick_en && !cnt_ld && !clr_hit && (cnt_q == '1)) |=> flags[EV_WRP]);

  p_load_wins_r10: assert property (@(posedge clk) disable iff (rst)
    cnt_ld |=> (cnt_q == $past(cnt_ld_val)));

  p_irq_level_r11: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (irq_req == $past(|(flags & ien))));

  p_wrap_first_r12: assert property (@(posedge clk) disable iff (rst)
    (flags[EV_WRP] && ien[EV_WRP]) |=> (irq_code == 5'd18));

  p_code_range_r12: assert property (@(posedge clk) disable iff (rst)
    irq_req |-> (irq_code >= 5'd16 && irq_code <= 5'd18));
endmodule

bind dual_cmp_timer tmr_checker #(.CODE_W(CODE_W)) u_chk (
  .clk(clk), .rst(rst), .tick_en(tick_en), .cnt_ld(cnt_ld),
  .cnt_ld_val(cnt_ld_val), .cnt_q(cnt_q), .cmp_a(cmp_a_w),
  .clr_on_a(clr_on_a), .flags(flags), .ien(ien),
  .irq_req(irq_req), .irq_code(irq_code)
);

// File: tb/sim_dual_cmp_timer.sv
`timescale 1ns/1ps
module sim_dual_cmp_timer;
  localparam logic [15:0] BASE = 16'hFF90;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        tick = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        irq_req;
  logic [4:0]  irq_code;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  dual_cmp_timer u0 (
    .clk(clk), .rst(rst), .tick(tick), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_req(irq_req), .irq_code(irq_code)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input int ofs, input int data, input logic with_tick = 1'b0);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = BASE + 16'(ofs);
    bus_wdata = 8'(data); tick = with_tick;
    @(posedge clk);
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; tick = 1'b0;
  endtask

  task automatic rd(input int ofs, output int data);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = BASE + 16'(ofs);
    @(posedge clk);
    #1 data = int'(bus_rdata);
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic rd_chk(input string req, input int ofs, input int exp);
    int v;
    rd(ofs, v);
    check(req, v, exp);
  endtask

  task automatic set_cnt(input int val);
    wr(2, val >> 8);
    wr(3, val & 8'hFF);
  endtask

  task automatic cnt_chk(input string req, input int exp);
    int h, l;
    rd(2, h);
    rd(3, l);
    check(req, (h << 8) | l, exp);
  endtask

  task automatic pulse(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic t_reset;
    check("R1 irq", int'(irq_req), 0);
    rd_chk("R1 ien", 0, 8'h00);
    rd_chk("R1 status", 1, 8'h00);
    rd_chk("R1 ctrl", 6, 8'h00);
    rd_chk("R1 bank", 7, 8'h00);
    rd_chk("R1 cmpA hi", 4, 8'hFF);
    cnt_chk("R1 counter", 16'h0000);
  endtask

  task automatic t_access;
    wr(0, 8'hFF);
    rd_chk("R2 ien mask", 0, 8'h0E);
    wr(0, 8'h00);
    wr(7, 0); wr(4, 8'h00); wr(5, 8'h20);
    wr(7, 1); wr(4, 8'h00); wr(5, 8'h30);
    rd_chk("R5 bank1 hi", 4, 8'h00);
    rd_chk("R5 bank1 lo", 5, 8'h30);
    rd_chk("R2 bank reg", 7, 8'h01);
    wr(7, 0);
    rd_chk("R5 bank0 lo", 5, 8'h20);
    wr(2, 8'h12);
    rd_chk("R4 hi staged only", 2, 8'h00);
    wr(3, 8'h34);
    cnt_chk("R4 pair commit", 16'h1234);
  endtask

  task automatic t_count;
    set_cnt(16'h0010);
    wr(6, 1);
    pulse(3);
    cnt_chk("R3 three ticks", 16'h0013);
    wr(6, 0);
    pulse(2);
    cnt_chk("R3 disabled hold", 16'h0013);
    wr(6, 1);
  endtask

  task automatic t_cmp_a;
    wr(1, 8'h01);
    set_cnt(16'h0020);
    pulse(1);
    cnt_chk("R6 clear on A", 16'h0000);
    rd_chk("R6 flag A", 1, 8'h09);
    wr(1, 8'h08);
    set_cnt(16'h0020);
    pulse(1);
    cnt_chk("R6 no clear", 16'h0021);
    wr(1, 8'h00);
    rd_chk("R6 flag A cleared", 1, 8'h00);
  endtask

  task automatic t_cmp_b_and_clear;
    wr(1, 8'h01);
    set_cnt(16'h0030);
    pulse(1);
    cnt_chk("R7 B no clear", 16'h0031);
    wr(1, 8'h01);
    rd_chk("R9 zero w/o read kept", 1, 8'h05);
    wr(1, 8'h05);
    rd_chk("R9 write one kept", 1, 8'h05);
    wr(1, 8'h01);
    rd_chk("R9 read-then-zero clears", 1, 8'h01);
    wr(1, 8'h00);
  endtask

  task automatic t_wrap;
    set_cnt(16'hFFFF);
    pulse(1);
    cnt_chk("R8 wrap count", 16'h0000);
    rd_chk("R8 wrap flag", 1, 8'h02);
    wr(1, 8'h00);
    rd_chk("R8 wrap flag cleared", 1, 8'h00);
  endtask

  task automatic t_collide;
    set_cnt(16'h0030);
    wr(2, 8'h00);
    wr(3, 8'h40, 1'b1);
    cnt_chk("R10 write wins", 16'h0040);
    rd_chk("R10 no B flag", 1, 8'h00);
  endtask

  task automatic t_irq;
    int s;
    wr(0, 8'h0E);
    wr(7, 0); wr(4, 8'hFF); wr(5, 8'hFF);
    set_cnt(16'hFFFF);
    check("R11 idle", int'(irq_req), 0);
    pulse(1);
    @(negedge clk);
    check("R11 raised", int'(irq_req), 1);
    check("R12 wrap beats A", int'(irq_code), 18);
    rd(1, s);
    check("R12 both flags", s, 8'h0A);
    wr(1, 8'h08);
    @(negedge clk);
    check("R12 A after wrap cleared", int'(irq_code), 16);
    check("R11 still high", int'(irq_req), 1);
    wr(0, 8'h00);
    @(negedge clk);
    check("R11 dropped", int'(irq_req), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk) rst = 1'b0;
    @(negedge clk);
    t_reset;
    t_access;
    t_count;
    t_cmp_a;
    t_cmp_b_and_clear;
    t_wrap;
    t_collide;
    t_irq;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule